// File: doc/BRIEF.md
# Two-Wire Debug Master Frame Engine

This block is the master side of a two-wire debug link made of one clock pin and one bidirectional data pin. A client hands it one request at a time: the frame kind, an address value, a payload of up to four bytes and a two-bit byte-count code. The engine then produces the complete frame on the pins. It strobes the clock, shifts bits out or in least significant bit first, and hands the data pin over to the target at fixed field boundaries. For data frames it keeps strobing through a target-controlled WAIT field until the target answers with a 1. It ends every frame with a STOP strobe. The same request port also asks for a long target reset pulse on the clock pin.

Every phase length is a run-time cycle count. There is a set-up time before each falling edge, a low time and a high time, and the data pin is sampled at the end of the high time. The reset pulse has its own low and high counts, and a limit caps the number of WAIT strobes. The request side is a valid/ready stream: a request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole of a frame, so a client that holds `req_valid` high simply waits, and the fields it offers meanwhile are not used. The result comes back as a one-cycle `rsp_valid` pulse with no back-pressure. The client must capture `rsp_data` and `rsp_err` in that cycle, or later while the engine is idle, because both hold until the next request is taken.

Top module: `twd_frame_master`

## Requirements
- R1: After reset the engine is idle. `busy`=0, `req_ready`=1, `rsp_valid`=0, `ck_oe`=0, `ck_o`=1 and `dat_oe`=0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response pulse. Requests offered during that time start no frame and do not alter the frame in progress. `req_ready` is high again in the cycle after `rsp_valid`.
- R3: Each frame begins with a START strobe and then two instruction strobes, bit 0 first. The codes are `req_op` 3 = address write (sends 1,1), 2 = address read (sends 0,1), 1 = data write (sends 1,0) and 0 = data read (sends 0,0).
- R4: `dat_oe` is 0 during the START strobe, the STOP strobe, every WAIT strobe, the address field of an address read and the payload of a data read. It is 1 during the instruction and length fields, the address field of an address write and the payload of a data write. While `dat_oe` is 0, `dat_o` is 0.
- R5: The address field is ADDR_W strobes, bit 0 first. An address write drives `req_addr`. An address read samples the target and returns the value in `rsp_data[ADDR_W-1:0]`, with the upper bits 0.
- R6: Data frames send `req_len` as two bits, bit 0 first, then a payload of (`req_len`+1)×8 bits, bit 0 first. On a data read, the first payload bit received lands in `rsp_data[0]`, and bits above the payload are 0.
- R7: A data write has its WAIT field after the payload. A data read has its WAIT field before the payload. In the WAIT field the data pin is sampled once per strobe. The first strobe that samples 1 is the last WAIT strobe.
- R8: If `cfg_wait_max` WAIT strobes (0 counts as 1) all sample 0, the engine goes directly to STOP and reports `rsp_err`=1. Otherwise `rsp_err`=0.
- R9: Each strobe keeps the clock high for `cfg_setup` cycles with the data already set, low for `cfg_low` cycles, then high for `cfg_high` cycles. The data pin is sampled at the end of the high time, and a zero count acts as 1. `dat_o` and `dat_oe` never change while the clock is low.
- R10: `req_op` values 4 to 7 produce a reset pulse. The clock is low for `cfg_rst_low` cycles and then high for `cfg_rst_high` cycles, the data pin is not driven, and then `rsp_valid` pulses.
- R11: `rsp_valid` is a single-cycle pulse. It comes `cfg_high` cycles after the last rising clock edge of the frame (`cfg_rst_high` for a reset pulse), and `rsp_data` and `rsp_err` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_op | input | 3 | Frame kind: 0 data read, 1 data write, 2 address read, 3 address write, 4-7 reset pulse |
| req_addr | input | ADDR_W | Address value for an address write |
| req_len | input | 2 | Payload byte count minus one |
| req_wdata | input | 32 | Payload for a data write, byte 0 in bits 7:0 |
| cfg_setup | input | CNT_W | Data set-up cycles before each falling edge |
| cfg_low | input | CNT_W | Clock low cycles per strobe |
| cfg_high | input | CNT_W | Clock high cycles before sampling |
| cfg_rst_low | input | CNT_W | Clock low cycles of the reset pulse |
| cfg_rst_high | input | CNT_W | Clock high cycles after the reset pulse |
| cfg_wait_max | input | WAIT_W | Maximum WAIT strobes |
| busy | output | 1 | Frame or reset pulse in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Received address or payload |
| rsp_err | output | 1 | WAIT limit reached in the last frame |
| ck_o | output | 1 | Clock pin output value |
| ck_oe | output | 1 | Clock pin driver enable |
| dat_o | output | 1 | Data pin output value |
| dat_oe | output | 1 | Data pin driver enable |
| dat_i | input | 1 | Data pin input value |

## Verification
A wrong field state appears at the pins within one strobe. A stuck or skipped bit counter lengthens or shortens the run of rising clock edges and moves the point where `dat_oe` changes. A bad instruction or bit index shows as a wrong driven bit, sampled at the next rising edge. A WAIT counter or exit fault changes the strobe count of the frame and the value of `rsp_err` in the response pulse. A packer fault shows as a wrong `rsp_data` at that pulse. A strobe timer fault changes the low time and the rise-to-rise spacing on the very first strobe.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int LEN_W  = 2;
  localparam int DATA_W = 8 << LEN_W;

  typedef enum logic [2:0] {
    OP_DRD = 3'd0,
    OP_DWR = 3'd1,
    OP_ARD = 3'd2,
    OP_AWR = 3'd3,
    OP_RST = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_START, ST_INS, ST_ADDR,
    ST_LEN, ST_WAIT, ST_DATA, ST_STOP, ST_DONE
  } fst_e;

  typedef enum logic [1:0] { PH_SU, PH_LO, PH_HI } ph_e;
endpackage

// File: rtl/twd_strobe.sv
module twd_strobe #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] len_su,
  input  logic [CNT_W-1:0] len_lo,
  input  logic [CNT_W-1:0] len_hi,
  output logic             ck_low,
  output logic             fin
);
  import twd_pkg::*;

  ph_e              ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur;
  logic             last;

  function automatic logic [CNT_W-1:0] at_least1(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  always_comb begin
    case (ph)
      PH_SU:   cur = at_least1(len_su);
      PH_LO:   cur = at_least1(len_lo);
      default: cur = at_least1(len_hi);
    endcase
    last = (cnt + CNT_W'(1)) >= cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_SU;
      cnt <= '0;
    end else if (!run) begin
      ph  <= PH_SU;
      cnt <= '0;
    end else if (last) begin
      cnt <= '0;
      case (ph)
        PH_SU:   ph <= PH_LO;
        PH_LO:   ph <= PH_HI;
        default: ph <= PH_SU;
      endcase
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign ck_low = run && (ph == PH_LO);
  assign fin    = run && (ph == PH_HI) && last;

  // R9: a sample point is always followed by a fresh set-up phase
  p_fin_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  // R9: the clock only goes low after a set-up phase
  p_low_after_su_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(ck_low)) |-> ($past(ph) == PH_SU));
endmodule

// File: rtl/twd_rx_pack.sv
module twd_rx_pack #(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic [IW-1:0] idx,
  input  logic          bit_in,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data <= '0;
    else if (clr)    data <= '0;
    else if (cap)    data[idx] <= bit_in;
  end

  // R6: a new request starts from an empty result word
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cap) |=> (data == '0));
endmodule

// File: rtl/twd_frame_master.sv
module twd_frame_master #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 16,
  localparam int DW    = twd_pkg::DATA_W,
  localparam int BC_W  = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  input  logic [DW-1:0]     req_wdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_low,
  input  logic [CNT_W-1:0]  cfg_high,
  input  logic [CNT_W-1:0]  cfg_rst_low,
  input  logic [CNT_W-1:0]  cfg_rst_high,
  input  logic [WAIT_W-1:0] cfg_wait_max,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_err,
  output logic              ck_o,
  output logic              ck_oe,
  output logic              dat_o,
  output logic              dat_oe,
  input  logic              dat_i
);
  import twd_pkg::*;

  fst_e              st;
  logic [1:0]        op;
  logic [DW-1:0]     addr_x;
  logic [1:0]        len;
  logic [DW-1:0]     wdata;
  logic [BC_W-1:0]   bcnt;
  logic [WAIT_W-1:0] wcnt;
  logic              err;

  logic              run, ck_low, fin, cap, take, bitv, drive;
  logic [BC_W:0]     flen;
  logic              fld_last;
  logic [CNT_W-1:0]  su_sel, lo_sel, hi_sel;
  logic [WAIT_W-1:0] wait_lim;
  logic              is_addr, is_wr;

  assign is_addr  = op[1];
  assign is_wr    = op[0];
  assign take     = req_valid && (st == ST_IDLE);
  assign wait_lim = (cfg_wait_max == '0) ? WAIT_W'(1) : cfg_wait_max;
  assign run      = (st != ST_IDLE) && (st != ST_DONE);

  always_comb begin
    su_sel = cfg_setup;
    lo_sel = cfg_low;
    hi_sel = cfg_high;
    if (st == ST_RST) begin
      su_sel = CNT_W'(1);
      lo_sel = cfg_rst_low;
      hi_sel = cfg_rst_high;
    end
  end

  twd_strobe #(.CNT_W(CNT_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .run(run),
    .len_su(su_sel), .len_lo(lo_sel), .len_hi(hi_sel),
    .ck_low(ck_low), .fin(fin)
  );

  always_comb begin
    case (st)
      ST_INS, ST_LEN: flen = (BC_W+1)'(2);
      ST_ADDR:        flen = (BC_W+1)'(ADDR_W);
      ST_DATA:        flen = (BC_W+1)'((32'(len) + 32'd1) * 32'd8);
      default:        flen = (BC_W+1)'(1);
    endcase
    fld_last = ({1'b0, bcnt} == (flen - (BC_W+1)'(1)));
  end

  always_comb begin
    drive = 1'b0;
    bitv  = 1'b0;
    case (st)
      ST_INS:  begin drive = 1'b1;  bitv = op[bcnt[0]];  end
      ST_LEN:  begin drive = 1'b1;  bitv = len[bcnt[0]]; end
      ST_ADDR: begin drive = !is_wr ? 1'b0 : 1'b1; bitv = addr_x[bcnt]; end
      ST_DATA: begin drive = is_wr; bitv = wdata[bcnt];  end
      default: ;
    endcase
  end

  assign dat_oe = drive;
  assign dat_o  = drive & bitv;
  assign cap    = fin && !is_wr && ((st == ST_ADDR) || (st == ST_DATA));

  twd_rx_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(take), .cap(cap),
    .idx(bcnt), .bit_in(dat_i), .data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op <= '0; addr_x <= '0; len <= '0; wdata <= '0;
      bcnt <= '0; wcnt <= '0; err <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          op     <= req_op[1:0];
          addr_x <= DW'(req_addr);
          len    <= req_len;
          wdata  <= req_wdata;
          bcnt   <= '0;
          wcnt   <= '0;
          err    <= 1'b0;
          st     <= req_op[2] ? ST_RST : ST_START;
        end
        ST_DONE: st <= ST_IDLE;
        default: if (fin) begin
          bcnt <= fld_last ? '0 : bcnt + BC_W'(1);
          case (st)
            ST_RST:   st <= ST_DONE;
            ST_START: begin st <= ST_INS; bcnt <= '0; end
            ST_INS:   if (fld_last) st <= is_addr ? ST_ADDR : ST_LEN;
            ST_ADDR:  if (fld_last) st <= ST_STOP;
            ST_LEN:   if (fld_last) begin
              st   <= is_wr ? ST_DATA : ST_WAIT;
              wcnt <= '0;
            end
            ST_DATA:  if (fld_last) begin
              st   <= is_wr ? ST_WAIT : ST_STOP;
              wcnt <= '0;
            end
            ST_WAIT: begin
              bcnt <= '0;
              if (dat_i) st <= is_wr ? ST_STOP : ST_DATA;
              else if ((wcnt + WAIT_W'(1)) >= wait_lim) begin
                st  <= ST_STOP;
                err <= 1'b1;
              end else wcnt <= wcnt + WAIT_W'(1);
            end
            default:  st <= ST_DONE;
          endcase
        end
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_DONE);
  assign rsp_err   = err;
  assign ck_oe     = (st != ST_IDLE);
  assign ck_o      = ~ck_low;

  // R9: data pin value and ownership are frozen while the clock is low
  p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_oe && !ck_o && $past(ck_oe && !ck_o)) |-> ($stable(dat_o) && $stable(dat_oe)));
  // R4: the target owns the pin during WAIT, START and STOP
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT || st == ST_START || st == ST_STOP || st == ST_RST) |-> !dat_oe);
  // R8: WAIT never runs past its limit
  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> (wcnt < wait_lim));
  // R11: completion is a single pulse
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2: engine accepts again right after the pulse
  p_ready_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !busy));
  // R2: while busy, no request is taken
  p_no_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);
endmodule

// File: tb/sim_twd_frame_master.sv
module sim_twd_frame_master;
  localparam int AW = 8;
  localparam int CW = 16;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_len = '0;
  logic [31:0] req_wdata = '0;
  logic [CW-1:0] cfg_setup = 16'd2, cfg_low = 16'd3, cfg_high = 16'd2;
  logic [CW-1:0] cfg_rst_low = 16'd20, cfg_rst_high = 16'd5;
  logic [WW-1:0] cfg_wait_max = 16'd6;
  logic busy, rsp_valid, rsp_err, ck_o, ck_oe, dat_o, dat_oe;
  logic [31:0] rsp_data;
  logic dat_i = 1'b0;

  always #4 clk = ~clk;

  twd_frame_master #(.ADDR_W(AW), .CNT_W(CW), .WAIT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .cfg_rst_low(cfg_rst_low), .cfg_rst_high(cfg_rst_high), .cfg_wait_max(cfg_wait_max),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .ck_o(ck_o), .ck_oe(ck_oe), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i)
  );

  int total = 0;
  int bad = 0;

  int nstr, ep, lo_min, lo_max, hi_min, hi_max, rise_gap, ready_busy;
  bit mo[64], oe[64], emo[64], eoe[64], resp[64];
  logic [31:0] got_data;
  logic got_err;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    ep = 0;
    for (int i = 0; i < 64; i++) begin resp[i] = 1'b0; emo[i] = 1'b0; eoe[i] = 1'b0; end
  endtask

  task automatic push(input bit v, input bit o);
    emo[ep] = v; eoe[ep] = o; ep++;
  endtask

  task automatic run_frame(input logic [2:0] op, input logic [7:0] a, input logic [1:0] ln,
                           input logic [31:0] wd, input bit spam);
    int lrun, hrun, since;
    bit prev, fin_seen;
    nstr = 0; lo_min = 9999; lo_max = 0; hi_min = 9999; hi_max = 0;
    rise_gap = -1; ready_busy = 0; lrun = 0; hrun = 0; since = 0; prev = 1'b1;
    fin_seen = 1'b0;
    @(negedge clk);
    req_op = op; req_addr = a; req_len = ln; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    if (spam) begin req_op = 3'd2; req_addr = 8'hFF; req_len = 2'd3; req_wdata = '1; end
    else req_valid = 1'b0;
    for (int c = 0; c < 5000 && !fin_seen; c++) begin
      if (busy && req_ready) ready_busy++;
      if (ck_oe && !ck_o) begin
        if (prev && nstr > 0) begin
          if (hrun < hi_min) hi_min = hrun;
          if (hrun > hi_max) hi_max = hrun;
        end
        lrun++;
      end else if (ck_oe && ck_o && !prev) begin
        mo[nstr] = dat_o; oe[nstr] = dat_oe;
        dat_i = resp[nstr];
        nstr++;
        if (lrun < lo_min) lo_min = lrun;
        if (lrun > lo_max) lo_max = lrun;
        lrun = 0; hrun = 1; since = 0;
      end else begin
        hrun++; since++;
      end
      prev = ck_oe ? ck_o : 1'b1;
      if (rsp_valid) begin
        got_data = rsp_data; got_err = rsp_err; rise_gap = since;
        req_valid = 1'b0; fin_seen = 1'b1;
      end
      @(negedge clk);
    end
    if (!fin_seen) chk(1'b0, "frame timeout", 0, 1);
    dat_i = 1'b0;
  endtask

  task automatic cmp_seq(input string tag);
    int first;
    first = -1;
    for (int i = 0; i < ep; i++)
      if (first < 0 && (mo[i] != emo[i] || oe[i] != eoe[i])) first = i;
    chk(nstr == ep, {tag, " strobe count"}, nstr, ep);
    chk(first < 0, {tag, " pin bits (index of first mismatch)"}, first, -1);
  endtask

  task automatic t_reset_state();
    chk(!busy && req_ready && !rsp_valid, "R1 idle flags", {busy, req_ready, rsp_valid}, 3'b010);
    chk(!ck_oe && ck_o && !dat_oe, "R1 idle pins", {ck_oe, ck_o, dat_oe}, 3'b010);
  endtask

  task automatic t_addr_write();
    clear_model();
    push(0, 0); push(1, 1); push(1, 1);
    for (int i = 0; i < 8; i++) push(8'hA5 >> i, 1);
    push(0, 0);
    run_frame(3'd3, 8'hA5, 2'd0, 32'h0, 1'b0);
    cmp_seq("R3 R4 R5 address write");
    chk(lo_min == 3 && lo_max == 3, "R9 low width", lo_max, 3);
    chk(hi_min == 4 && hi_max == 4, "R9 high span between strobes", hi_max, 4);
    chk(rise_gap == 2, "R11 last rise to pulse", rise_gap, 2);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11 single pulse / R2 ready", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_addr_read();
    clear_model();
    push(0, 0); push(0, 1); push(1, 1);
    for (int i = 0; i < 8; i++) begin push(0, 0); resp[3 + i] = (8'h5C >> i) & 1; end
    push(0, 0);
    run_frame(3'd2, 8'h00, 2'd0, 32'h0, 1'b0);
    cmp_seq("R3 R4 address read");
    chk(got_data == 32'h5C, "R5 address read value", got_data, 32'h5C);
  endtask

  task automatic t_data_write();
    clear_model();
    push(0, 0); push(1, 1); push(0, 1); push(1, 1); push(0, 1);
    for (int i = 0; i < 16; i++) push((32'hBEEF >> i) & 1, 1);
    push(0, 0); push(0, 0); push(0, 0); push(0, 0);
    resp[23] = 1'b1;
    run_frame(3'd1, 8'h0, 2'd1, 32'hBEEF, 1'b0);
    cmp_seq("R6 R7 data write two bytes");
    chk(got_err == 1'b0, "R8 no error", got_err, 0);
  endtask

  task automatic t_data_read4();
    clear_model();
    push(0, 0); push(0, 1); push(0, 1); push(1, 1); push(1, 1);
    push(0, 0); resp[5] = 1'b1;
    for (int i = 0; i < 32; i++) begin push(0, 0); resp[6 + i] = (32'h12345678 >> i) & 1; end
    push(0, 0);
    run_frame(3'd0, 8'h0, 2'd3, 32'h0, 1'b0);
    cmp_seq("R4 R7 data read four bytes");
    chk(got_data == 32'h12345678, "R6 four-byte packing", got_data, 32'h12345678);
  endtask

  task automatic t_data_read1();
    clear_model();
    push(0, 0); push(0, 1); push(0, 1); push(0, 1); push(0, 1);
    push(0, 0); push(0, 0); push(0, 0); resp[7] = 1'b1;
    for (int i = 0; i < 8; i++) begin push(0, 0); resp[8 + i] = (8'hC3 >> i) & 1; end
    push(0, 0);
    run_frame(3'd0, 8'h0, 2'd0, 32'hFFFF_FFFF, 1'b0);
    cmp_seq("R7 data read with two WAIT zeros");
    chk(got_data == 32'h0000_00C3, "R6 one-byte packing, upper bits zero", got_data, 32'hC3);
  endtask

  task automatic t_wait_timeout();
    clear_model();
    push(0, 0); push(1, 1); push(0, 1); push(0, 1); push(0, 1);
    for (int i = 0; i < 8; i++) push((8'h3C >> i) & 1, 1);
    for (int i = 0; i < 6; i++) push(0, 0);
    push(0, 0);
    run_frame(3'd1, 8'h0, 2'd0, 32'h3C, 1'b0);
    cmp_seq("R8 WAIT limit strobe count");
    chk(got_err == 1'b1, "R8 error flag", got_err, 1);
  endtask

  task automatic t_reset_pulse();
    clear_model();
    push(0, 0);
    run_frame(3'd5, 8'h0, 2'd0, 32'h0, 1'b0);
    cmp_seq("R10 reset pulse");
    chk(lo_min == 20 && lo_max == 20, "R10 reset low width", lo_max, 20);
    chk(rise_gap == 5, "R10 R11 reset high time", rise_gap, 5);
  endtask

  task automatic t_busy_ignore();
    clear_model();
    push(0, 0); push(1, 1); push(1, 1);
    for (int i = 0; i < 8; i++) push(8'h3C >> i, 1);
    push(0, 0);
    run_frame(3'd3, 8'h3C, 2'd0, 32'h0, 1'b1);
    cmp_seq("R2 frame unaffected by offered request");
    chk(ready_busy == 0, "R2 ready low while busy", ready_busy, 0);
    begin
      int act;
      act = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (ck_oe || busy) act++;
      end
      chk(act == 0, "R2 no frame from ignored request", act, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_addr_write();
    t_addr_read();
    t_data_write();
    t_data_read4();
    t_data_read1();
    t_wait_timeout();
    t_data_read1();
    chk(got_err == 1'b0, "R8 error cleared by next frame", got_err, 0);
    t_reset_pulse();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule